// File: doc/BRIEF.md
# Per-Input Assertion Level Tracker

This block keeps the net assertion level for each of a bank of interrupt inputs. Any number of sources may drive the same input, and each source reports its activity as separate events rather than as a wire level. Every input has a saturating up/down count. An assert event adds one to the count. A deassert event takes one away. A pulse event is an assert followed at once by a deassert. At either end the count holds its value instead of wrapping, and the event reports a distinct error code. The input reads as asserted whenever its count is non-zero.

Only a count that moves from zero to one produces a delivery request, which is sent to the downstream delivery engine. Further asserts on an input that is already held, and the release back to zero, produce no request. Events arrive one per cycle through a valid/index/kind interface. A response code comes back one cycle later. Two saturating statistics counters keep totals of overflow events and underflow events.

Top module: `pin_assert_tracker`

## Requirements
- R1: An assert event (kind 0) on an input whose count is below its maximum adds one to the count. The input's bit in `asserted` equals (count != 0), and it reflects the new count in the cycle the response appears.
- R2: An assert event on an input whose count is at its maximum (2^CNT_W-1) leaves the count unchanged and returns code 1 (overflow). It raises no request.
- R3: A deassert event (kind 1) on a non-zero count takes one away from it and returns code 0. On a zero count it leaves the count at zero and returns code 2 (underflow).
- R4: A count that goes from 0 to 1 raises `req_valid` for one cycle, with `req_index` equal to the input, in the same cycle as the response. A deassert never raises a request. An assert from a non-zero count never raises one either.
- R5: A pulse event (kind 2) leaves the count where it was and returns code 0. It raises a request when the count was zero. When the count is at its maximum, it returns code 1 and the deassert half is skipped, so the count stays at its maximum.
- R6: An event with an index of NUM_INPUTS or more, or with kind 3, returns code 3 (invalid argument). It changes no count and no statistic, and it raises no request.
- R7: `ovf_total` counts events that returned code 1, and `unf_total` counts events that returned code 2. Each saturates at 2^STAT_W-1.
- R8: After reset every count is zero. `asserted`, both statistics and both valid outputs are all low.
- R9: Every event presented with `ev_valid` produces exactly one `rsp_valid` cycle on the next clock. A cycle without `ev_valid` produces no response and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_index | input | IDX_W | Target input number |
| ev_kind | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 reserved |
| rsp_valid | output | 1 | Response for the previous cycle's event |
| rsp_code | output | 2 | 0 ok, 1 overflow, 2 underflow, 3 invalid argument |
| req_valid | output | 1 | Delivery request (count went 0 to 1) |
| req_index | output | IDX_W | Input that raised the request |
| asserted | output | NUM_INPUTS | Per-input flag, count != 0 |
| ovf_total | output | STAT_W | Saturating overflow event total |
| unf_total | output | STAT_W | Saturating underflow event total |

## Verification
The counts themselves are never visible at the ports. A count that is wrong by one shows up only at the next boundary the count reaches. The asserted flag drops one deassert early or late, an underflow or overflow code appears one event early or late, or a request goes missing or is doubled. For that reason the bench drives inputs across the whole count range, from zero up to saturation and back down. The first event after the divergence, at the boundary, exposes it within one cycle. A statistic that is wrong shows on the response cycle of the next error event.

// File: rtl/pat_pkg.sv
package pat_pkg;

    typedef enum logic [1:0] {
        EV_RAISE = 2'd0,
        EV_DROP  = 2'd1,
        EV_PULSE = 2'd2,
        EV_RSVD  = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        RC_OK        = 2'd0,
        RC_OVERFLOW  = 2'd1,
        RC_UNDERFLOW = 2'd2,
        RC_BADARG    = 2'd3
    } rsp_code_e;

endpackage

// File: rtl/pat_event_decode.sv
module pat_event_decode #(
    parameter int NUM_INPUTS = 32,
    parameter int IDX_W      = 6
) (
    input  logic                  ev_valid_i,
    input  logic [IDX_W-1:0]      ev_index_i,
    input  logic [1:0]            ev_kind_i,
    output logic                  legal_o,
    output logic [NUM_INPUTS-1:0] sel_o
);
    import pat_pkg::*;

    logic in_range;
    logic kind_ok;

    always_comb begin
        in_range = (int'(ev_index_i) < NUM_INPUTS);
        kind_ok  = (ev_kind_e'(ev_kind_i) != EV_RSVD);
        legal_o  = ev_valid_i && in_range && kind_ok;
    end

    for (genvar gi = 0; gi < NUM_INPUTS; gi++) begin : g_sel
        assign sel_o[gi] = legal_o && (ev_index_i == IDX_W'(gi));
    end

endmodule

// File: rtl/pat_level_cell.sv
module pat_level_cell #(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic [1:0] kind_i,
    output logic       asserted_o,
    output logic       ovf_o,
    output logic       unf_o,
    output logic       rise_o
);
    import pat_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cell_state_t;

    cell_state_t state_d, state_q;
    ev_kind_e    kind;
    logic        at_max;
    logic        at_zero;
    logic        ups;

    always_comb begin
        kind    = ev_kind_e'(kind_i);
        at_max  = &state_q.count;
        at_zero = (state_q.count == '0);
        ups     = (kind == EV_RAISE) || (kind == EV_PULSE);
        state_d = state_q;

        ovf_o  = sel_i && ups && at_max;
        unf_o  = sel_i && (kind == EV_DROP) && at_zero;
        rise_o = sel_i && ups && at_zero && !at_max;

        if (sel_i) begin
            unique case (kind)
                EV_RAISE: if (!at_max)  state_d.count = state_q.count + 1'b1;
                EV_DROP:  if (!at_zero) state_d.count = state_q.count - 1'b1;
                default:  state_d.count = state_q.count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign asserted_o = (state_q.count != '0);

endmodule

// File: rtl/pat_stat_counter.sv
module pat_stat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump_i,
    output logic [W-1:0] value_o
);
    typedef struct packed {
        logic [W-1:0] value;
    } stat_state_t;

    stat_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (bump_i && !(&state_q.value)) state_d.value = state_q.value + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign value_o = state_q.value;

endmodule

// File: rtl/pin_assert_tracker.sv
module pin_assert_tracker #(
    parameter int NUM_INPUTS = 32,
    parameter int CNT_W      = 8,
    parameter int STAT_W     = 16,
    parameter int IDX_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_valid,
    input  logic [IDX_W-1:0]      ev_index,
    input  logic [1:0]            ev_kind,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_code,
    output logic                  req_valid,
    output logic [IDX_W-1:0]      req_index,
    output logic [NUM_INPUTS-1:0] asserted,
    output logic [STAT_W-1:0]     ovf_total,
    output logic [STAT_W-1:0]     unf_total
);
    import pat_pkg::*;

    typedef struct packed {
        logic             rsp_valid;
        logic [1:0]       rsp_code;
        logic             req_valid;
        logic [IDX_W-1:0] req_index;
    } resp_state_t;

    logic                  legal;
    logic [NUM_INPUTS-1:0] sel;
    logic [NUM_INPUTS-1:0] ovf_v;
    logic [NUM_INPUTS-1:0] unf_v;
    logic [NUM_INPUTS-1:0] rise_v;
    logic                  any_ovf;
    logic                  any_unf;
    logic                  any_rise;
    resp_state_t           resp_d, resp_q;

    pat_event_decode #(
        .NUM_INPUTS(NUM_INPUTS),
        .IDX_W     (IDX_W)
    ) u_decode (
        .ev_valid_i(ev_valid),
        .ev_index_i(ev_index),
        .ev_kind_i (ev_kind),
        .legal_o   (legal),
        .sel_o     (sel)
    );

    for (genvar gi = 0; gi < NUM_INPUTS; gi++) begin : g_cell
        pat_level_cell #(
            .CNT_W(CNT_W)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_i     (sel[gi]),
            .kind_i    (ev_kind),
            .asserted_o(asserted[gi]),
            .ovf_o     (ovf_v[gi]),
            .unf_o     (unf_v[gi]),
            .rise_o    (rise_v[gi])
        );
    end

    always_comb begin
        any_ovf  = |ovf_v;
        any_unf  = |unf_v;
        any_rise = |rise_v;

        resp_d           = resp_q;
        resp_d.rsp_valid = ev_valid;
        resp_d.req_valid = any_rise;
        if (any_rise) resp_d.req_index = ev_index;

        if (!ev_valid)    resp_d.rsp_code = RC_OK;
        else if (!legal)  resp_d.rsp_code = RC_BADARG;
        else if (any_ovf) resp_d.rsp_code = RC_OVERFLOW;
        else if (any_unf) resp_d.rsp_code = RC_UNDERFLOW;
        else              resp_d.rsp_code = RC_OK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    pat_stat_counter #(.W(STAT_W)) u_ovf_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump_i (any_ovf),
        .value_o(ovf_total)
    );

    pat_stat_counter #(.W(STAT_W)) u_unf_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump_i (any_unf),
        .value_o(unf_total)
    );

    assign rsp_valid = resp_q.rsp_valid;
    assign rsp_code  = resp_q.rsp_code;
    assign req_valid = resp_q.req_valid;
    assign req_index = resp_q.req_index;

endmodule

// File: rtl/pin_assert_tracker_chk.sv
module pin_assert_tracker_chk #(
    parameter int NUM_INPUTS = 32,
    parameter int STAT_W     = 16,
    parameter int IDX_W      = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ev_valid,
    input logic [IDX_W-1:0]      ev_index,
    input logic [1:0]            ev_kind,
    input logic                  rsp_valid,
    input logic [1:0]            rsp_code,
    input logic                  req_valid,
    input logic [IDX_W-1:0]      req_index,
    input logic [NUM_INPUTS-1:0] asserted,
    input logic [STAT_W-1:0]     ovf_total,
    input logic [STAT_W-1:0]     unf_total
);
    a_r6_badarg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (int'(ev_index) >= NUM_INPUTS)) |=>
            (rsp_valid && rsp_code == 2'd3 && !req_valid && $stable(asserted)
             && $stable(ovf_total) && $stable(unf_total)));

    a_r4_req_only_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (rsp_valid && rsp_code == 2'd0));

    a_r4_new_flag_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (|(asserted & ~$past(asserted))) |-> req_valid);

    a_r1_one_flag_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(asserted ^ $past(asserted)) <= 1));

    a_r2_overflow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd1) |-> ($stable(asserted) && !req_valid));

    a_r7_underflow_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> ((unf_total != $past(unf_total)) || (&unf_total)));

    a_r9_event_answered: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> rsp_valid);

    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> (!rsp_valid && !req_valid));

endmodule

bind pin_assert_tracker pin_assert_tracker_chk #(
    .NUM_INPUTS(NUM_INPUTS),
    .STAT_W    (STAT_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .ev_index (ev_index),
    .ev_kind  (ev_kind),
    .rsp_valid(rsp_valid),
    .rsp_code (rsp_code),
    .req_valid(req_valid),
    .req_index(req_index),
    .asserted (asserted),
    .ovf_total(ovf_total),
    .unf_total(unf_total)
);

// File: tb/sim_pin_assert_tracker.sv
`timescale 1ns/1ps
module sim_pin_assert_tracker;
    localparam int N     = 32;
    localparam int CW    = 8;
    localparam int SW    = 4;
    localparam int IW    = 6;
    localparam int CMAX  = (1 << CW) - 1;
    localparam int SMAX  = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic [IW-1:0] ev_index = '0;
    logic [1:0]    ev_kind = 2'd0;
    logic          rsp_valid;
    logic [1:0]    rsp_code;
    logic          req_valid;
    logic [IW-1:0] req_index;
    logic [N-1:0]  asserted;
    logic [SW-1:0] ovf_total;
    logic [SW-1:0] unf_total;

    int unsigned tests = 0;
    int unsigned fails = 0;
    int cnt_m [N];
    int ovf_m = 0;
    int unf_m = 0;

    always #2 clk = ~clk;

    pin_assert_tracker #(
        .NUM_INPUTS(N), .CNT_W(CW), .STAT_W(SW), .IDX_W(IW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_index(ev_index),
        .ev_kind(ev_kind), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .req_valid(req_valid), .req_index(req_index), .asserted(asserted),
        .ovf_total(ovf_total), .unf_total(unf_total)
    );

    task automatic check(string tag, string what, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_flags();
        logic [N-1:0] f;
        for (int i = 0; i < N; i++) f[i] = (cnt_m[i] != 0);
        return f;
    endfunction

    // Caller is at a negedge; leaves at a negedge after checking.
    task automatic send(int kind, int idx);
        int    code = 0;
        bit    req = 1'b0;
        string tag;
        if (idx >= N || kind == 3) begin
            code = 3;
        end else if (kind == 0) begin
            if (cnt_m[idx] == CMAX) code = 1;
            else begin req = (cnt_m[idx] == 0); cnt_m[idx]++; end
        end else if (kind == 1) begin
            if (cnt_m[idx] == 0) code = 2;
            else cnt_m[idx]--;
        end else begin
            if (cnt_m[idx] == CMAX) code = 1;
            else req = (cnt_m[idx] == 0);
        end
        if (code == 1 && ovf_m < SMAX) ovf_m++;
        if (code == 2 && unf_m < SMAX) unf_m++;
        if (code == 3)      tag = "R6";
        else if (kind == 2) tag = "R5";
        else if (code == 1) tag = "R2";
        else if (code == 2) tag = "R3";
        else if (req)       tag = "R4";
        else if (kind == 1) tag = "R3";
        else                tag = "R1";

        ev_valid = 1'b1;
        ev_index = IW'(idx);
        ev_kind  = 2'(kind);
        @(negedge clk);
        ev_valid = 1'b0;
        check("R9", "rsp_valid", rsp_valid, 1);
        check(tag, "rsp_code", rsp_code, code);
        check(req ? "R4" : tag, "req_valid", req_valid, req);
        if (req) check("R4", "req_index", req_index, idx);
        check(tag == "R6" ? "R6" : "R1", "asserted", asserted, exp_flags());
        check("R7", "ovf_total", ovf_total, ovf_m);
        check("R7", "unf_total", unf_total, unf_m);
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R9", "idle rsp_valid", rsp_valid, 0);
        check("R9", "idle req_valid", req_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) cnt_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8", "rsp_valid", rsp_valid, 0);
        check("R8", "req_valid", req_valid, 0);
        check("R8", "asserted", asserted, 0);
        check("R8", "ovf_total", ovf_total, 0);
        check("R8", "unf_total", unf_total, 0);

        // R1/R3/R4/R5 sweep over every input: rise, fall, underflow, pulse
        for (int i = 0; i < N; i++) begin
            send(0, i);
            send(1, i);
            send(1, i);
            send(2, i);
        end
        idle_check();

        // R1/R4 overlapping asserters on input 7
        for (int k = 0; k < 3; k++) send(0, 7);
        send(2, 7);
        for (int k = 0; k < 3; k++) send(1, 7);

        // R6 invalid indices and reserved kind, while input 3 is held
        send(0, 3);
        for (int idx = N; idx < (1 << IW); idx++) send(idx % 3, idx);
        for (int i = 0; i < 4; i++) send(3, i);
        send(1, 3);

        // R2/R5 full range on input 5: climb to max, overflow, pulse at max
        for (int k = 0; k <= CMAX; k++) send(0, 5);
        send(2, 5);
        send(0, 5);
        // count must still be max: CMAX clean deasserts then underflow
        for (int k = 0; k <= CMAX; k++) send(1, 5);
        idle_check();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule